// File: doc/BRIEF.md
# Dual-Buffer Instruction Fetch Front End

This block is the fetch/decode stage of a small pattern-matching processor. Pattern instructions are stored in an instruction memory that returns read data one cycle after the address is presented. The stage presents one decoded instruction to a purely combinational execute stage and takes its orders from the control unit. The control unit can say that the first pattern instruction has started to match, that a later instruction matched, that the match failed, or that execution must jump to a new program address.

The stage holds two instruction buffers. While the engine is searching, the first instruction of the pattern stays current every cycle, and the following instruction is already held in the second buffer. When a match begins, the second buffer feeds the execute stage and keeps fetching ahead, while the first buffer keeps the pattern's opening instruction as a backup. If the match then fails, the backup is presented on the very next cycle and searching resumes with no stall. A jump to a new address (used for loops and returns) empties both buffers and costs exactly one empty cycle.

Top module: `dual_buf_fetch`

## Requirements
- R1: Reset clears both buffers, sets the program address to 0 and drops `cur_valid`. After reset is released, the instruction at address 0 becomes current on the second clock edge, and `cur_valid` is low after the first.
- R2: Memory reads use `imem_rd_en` and `imem_addr`, and the data appears on `imem_rdata` one cycle later. In the first cycle after reset is released, a read of address 0 is requested.
- R3: While searching with no start, fail or load request, the current instruction and its address stay the same from cycle to cycle.
- R4: A start request while searching, or an advance request while matching, makes the instruction at the next sequential address current after the next edge. This holds on every consecutive cycle, with no empty cycle, including the first advance straight after a start.
- R5: A fail request while matching makes the pattern's first instruction (the backup) current after the next edge with `cur_valid` high, and the stage returns to searching. A start on the following cycle again yields the next sequential instruction with no empty cycle.
- R6: These requests are ignored and leave the current instruction unchanged: advance or fail while searching, start while matching, and start or advance while `cur_valid` is low.
- R7: A load request with address A drops `cur_valid` for one cycle, then presents the instruction at A, with searching restarted from A. Load wins over fail and advance in the same cycle. When loads come back to back, only the last one takes effect.
- R8: When fail and advance arrive in the same cycle while matching, fail wins.
- R9: The instruction word is INSTR_W bits wide (38 by default). Bit INSTR_W-1 is the open-group flag. Bits INSTR_W-2..INSTR_W-3 are the inner operator, bits INSTR_W-4..INSTR_W-6 are the outer operator, and the low CLUSTER_W*CHAR_W bits are the reference characters. `dec_nop` is high exactly when the six operator bits are all zero.
- R10: Sequential addresses wrap modulo 2^PC_W, so the instruction after address 255 is address 0 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_rd_en | output | 1 | Instruction memory read request |
| imem_addr | output | PC_W | Instruction memory read address |
| imem_rdata | input | INSTR_W | Read data, one cycle after the request |
| mt_start | input | 1 | First pattern instruction matched |
| mt_advance | input | 1 | Current instruction matched, move on |
| mt_fail | input | 1 | Match failed, return to the pattern start |
| pc_load | input | 1 | Jump to a new program address |
| pc_load_addr | input | PC_W | Jump target |
| cur_valid | output | 1 | Current instruction is valid |
| cur_pc | output | PC_W | Address of the current instruction |
| cur_instr | output | INSTR_W | Raw current instruction |
| dec_open | output | 1 | Open-group flag |
| dec_int_op | output | 2 | Operator between reference characters |
| dec_ext_op | output | 3 | Loop / close operator |
| dec_ref | output | CLUSTER_W*CHAR_W | Reference characters |
| dec_nop | output | 1 | End-of-pattern marker |

## Verification
Two functions can land in the same cycle. A request from the control unit can arrive in the cycle where a memory read is still landing. The case that matters most is an advance or a start in the cycle where the next-instruction fill is arriving, so the buffer has not yet captured it. Sequences of a start straight after a fail, and of an advance straight after a start, create this case. Each expected current address is checked one edge later against the instruction word the bench computes for that address. A load issued while a base fill is landing, and a fail raised together with an advance or a load, cover the priority collisions.

// File: rtl/dbf_pkg.sv
`timescale 1ns/1ps
package dbf_pkg;
  localparam int OPC_W = 6;
  localparam int INT_W = 2;
  localparam int EXT_W = 3;

  typedef enum logic {MODE_SEEK = 1'b0, MODE_TRACK = 1'b1} mode_e;
  typedef enum logic {DST_BASE = 1'b0, DST_NEXT = 1'b1} dst_e;
endpackage

// File: rtl/dbf_slot.sv
`timescale 1ns/1ps
module dbf_slot #(
  parameter int W = 38
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         ld,
  input  logic [W-1:0] d,
  output logic         v,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      v <= 1'b0;
      q <= '0;
    end else if (clr) begin
      v <= 1'b0;
    end else if (ld) begin
      v <= 1'b1;
      q <= d;
    end
  end
endmodule

// File: rtl/dbf_decode.sv
`timescale 1ns/1ps
module dbf_decode
  import dbf_pkg::*;
#(
  parameter int INSTR_W = 38,
  localparam int REF_W = INSTR_W - OPC_W
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               open_f,
  output logic [INT_W-1:0]   int_op,
  output logic [EXT_W-1:0]   ext_op,
  output logic [REF_W-1:0]   ref_o,
  output logic               nop
);
  logic [OPC_W-1:0] opc;

  always_comb begin
    opc    = instr[INSTR_W-1 -: OPC_W];
    open_f = opc[OPC_W-1];
    int_op = opc[OPC_W-2 -: INT_W];
    ext_op = opc[EXT_W-1:0];
    ref_o  = instr[REF_W-1:0];
    nop    = (opc == '0);
  end
endmodule

// File: rtl/dbf_ctl.sv
`timescale 1ns/1ps
module dbf_ctl
  import dbf_pkg::*;
#(
  parameter int PC_W    = 8,
  parameter int INSTR_W = 38
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               advance,
  input  logic               fail,
  input  logic               load,
  input  logic [PC_W-1:0]    load_pc,
  input  logic [INSTR_W-1:0] rdata,
  input  logic               bak_v,
  input  logic [INSTR_W-1:0] bak_q,
  input  logic               nxt_v,
  input  logic [INSTR_W-1:0] nxt_q,
  output logic [1:0]         slot_clr,
  output logic [1:0]         slot_ld,
  output logic               rd_en,
  output logic [PC_W-1:0]    rd_addr,
  output logic               cur_v,
  output logic [PC_W-1:0]    cur_pc,
  output logic [INSTR_W-1:0] cur_ins,
  output logic               tracking,
  output logic [PC_W-1:0]    base_pc
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  mode_e               mode_q;
  dst_e                dst_q, dst_n;
  logic                req_q;
  logic [PC_W-1:0]     base_q, nxt_pc_q, cur_pc_q;
  logic                cur_v_q;
  logic [INSTR_W-1:0]  cur_ins_q, next_ins;
  logic                got_base, got_next, next_hit;
  logic                do_load, do_fail, do_step;

  always_comb begin
    got_base = req_q && (dst_q == DST_BASE);
    got_next = req_q && (dst_q == DST_NEXT);
    next_hit = nxt_v || got_next;
    next_ins = nxt_v ? nxt_q : rdata;
    do_load  = load;
    do_fail  = !load && fail && cur_v_q && (mode_q == MODE_TRACK);
    do_step  = !load && !do_fail && cur_v_q && next_hit &&
               (((mode_q == MODE_SEEK) && start) || ((mode_q == MODE_TRACK) && advance));

    rd_en   = 1'b1;
    rd_addr = nxt_pc_q;
    dst_n   = DST_NEXT;
    if (do_load) begin
      rd_addr = load_pc;
      dst_n   = DST_BASE;
    end else if (do_fail) begin
      rd_addr = base_q + ONE;
    end else if (do_step) begin
      rd_addr = nxt_pc_q + ONE;
    end else if (!(bak_v || got_base)) begin
      rd_addr = base_q;
      dst_n   = DST_BASE;
    end else if (!next_hit) begin
      rd_addr = nxt_pc_q;
    end else begin
      rd_en   = 1'b0;
    end

    slot_clr[0] = do_load;
    slot_ld[0]  = got_base;
    slot_clr[1] = do_load || do_fail || do_step;
    slot_ld[1]  = got_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= MODE_SEEK;
      dst_q     <= DST_BASE;
      req_q     <= 1'b0;
      base_q    <= '0;
      nxt_pc_q  <= ONE;
      cur_pc_q  <= '0;
      cur_v_q   <= 1'b0;
      cur_ins_q <= '0;
    end else begin
      req_q <= rd_en;
      dst_q <= dst_n;
      if (do_load) begin
        mode_q   <= MODE_SEEK;
        base_q   <= load_pc;
        nxt_pc_q <= load_pc + ONE;
        cur_v_q  <= 1'b0;
      end else if (do_fail) begin
        mode_q    <= MODE_SEEK;
        cur_ins_q <= bak_q;
        cur_pc_q  <= base_q;
        cur_v_q   <= 1'b1;
        nxt_pc_q  <= base_q + ONE;
      end else if (do_step) begin
        mode_q    <= MODE_TRACK;
        cur_ins_q <= next_ins;
        cur_pc_q  <= nxt_pc_q;
        cur_v_q   <= 1'b1;
        nxt_pc_q  <= nxt_pc_q + ONE;
      end else if (got_base) begin
        cur_ins_q <= rdata;
        cur_pc_q  <= base_q;
        cur_v_q   <= 1'b1;
      end
    end
  end

  assign cur_v    = cur_v_q;
  assign cur_pc   = cur_pc_q;
  assign cur_ins  = cur_ins_q;
  assign tracking = (mode_q == MODE_TRACK);
  assign base_pc  = base_q;
endmodule

// File: rtl/dual_buf_fetch.sv
`timescale 1ns/1ps
module dual_buf_fetch
  import dbf_pkg::*;
#(
  parameter int PC_W      = 8,
  parameter int CHAR_W    = 8,
  parameter int CLUSTER_W = 4,
  localparam int REF_W    = CHAR_W * CLUSTER_W,
  localparam int INSTR_W  = OPC_W + REF_W
) (
  input  logic               clk,
  input  logic               rst,
  output logic               imem_rd_en,
  output logic [PC_W-1:0]    imem_addr,
  input  logic [INSTR_W-1:0] imem_rdata,
  input  logic               mt_start,
  input  logic               mt_advance,
  input  logic               mt_fail,
  input  logic               pc_load,
  input  logic [PC_W-1:0]    pc_load_addr,
  output logic               cur_valid,
  output logic [PC_W-1:0]    cur_pc,
  output logic [INSTR_W-1:0] cur_instr,
  output logic               dec_open,
  output logic [INT_W-1:0]   dec_int_op,
  output logic [EXT_W-1:0]   dec_ext_op,
  output logic [REF_W-1:0]   dec_ref,
  output logic               dec_nop
);
  logic [1:0]         slot_clr, slot_ld, slot_v;
  logic [INSTR_W-1:0] slot_q [2];
  logic               tracking;
  logic [PC_W-1:0]    base_pc;

  // slot 0 keeps the pattern's first instruction, slot 1 runs ahead
  for (genvar s = 0; s < 2; s++) begin : g_slot
    dbf_slot #(.W(INSTR_W)) u_slot (
      .clk (clk),
      .rst (rst),
      .clr (slot_clr[s]),
      .ld  (slot_ld[s]),
      .d   (imem_rdata),
      .v   (slot_v[s]),
      .q   (slot_q[s])
    );
  end

  dbf_ctl #(.PC_W(PC_W), .INSTR_W(INSTR_W)) u_ctl (
    .clk      (clk),
    .rst      (rst),
    .start    (mt_start),
    .advance  (mt_advance),
    .fail     (mt_fail),
    .load     (pc_load),
    .load_pc  (pc_load_addr),
    .rdata    (imem_rdata),
    .bak_v    (slot_v[0]),
    .bak_q    (slot_q[0]),
    .nxt_v    (slot_v[1]),
    .nxt_q    (slot_q[1]),
    .slot_clr (slot_clr),
    .slot_ld  (slot_ld),
    .rd_en    (imem_rd_en),
    .rd_addr  (imem_addr),
    .cur_v    (cur_valid),
    .cur_pc   (cur_pc),
    .cur_ins  (cur_instr),
    .tracking (tracking),
    .base_pc  (base_pc)
  );

  dbf_decode #(.INSTR_W(INSTR_W)) u_dec (
    .instr  (cur_instr),
    .open_f (dec_open),
    .int_op (dec_int_op),
    .ext_op (dec_ext_op),
    .ref_o  (dec_ref),
    .nop    (dec_nop)
  );
endmodule

// File: rtl/dbf_checks.sv
`timescale 1ns/1ps
module dbf_checks #(
  parameter int PC_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            advance,
  input logic            fail,
  input logic            load,
  input logic            cur_valid,
  input logic [PC_W-1:0] cur_pc,
  input logic            tracking,
  input logic [PC_W-1:0] base_pc
);
  localparam logic [PC_W-1:0] ONE = PC_W'(1);

  // R1: reset leaves nothing current
  assert_reset_empty_R1: assert property (@(posedge clk) rst |=> !cur_valid);

  // R3: searching without requests holds the instruction
  assert_seek_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cur_valid && !tracking && !start && !load) |=> (cur_valid && $stable(cur_pc)));

  // R4: advance while matching moves to the next address, no gap
  assert_advance_step_R4: assert property (@(posedge clk) disable iff (rst)
    (cur_valid && tracking && advance && !fail && !load) |=>
      (cur_valid && cur_pc == $past(cur_pc) + ONE));

  // R5: failure brings back the backup at once
  assert_fail_resume_R5: assert property (@(posedge clk) disable iff (rst)
    (cur_valid && tracking && fail && !load) |=>
      (cur_valid && !tracking && cur_pc == $past(base_pc)));

  // R7: a load leaves one empty cycle
  assert_load_bubble_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> !cur_valid);
endmodule

bind dual_buf_fetch dbf_checks #(.PC_W(PC_W)) u_checks (
  .clk       (clk),
  .rst       (rst),
  .start     (mt_start),
  .advance   (mt_advance),
  .fail      (mt_fail),
  .load      (pc_load),
  .cur_valid (cur_valid),
  .cur_pc    (cur_pc),
  .tracking  (tracking),
  .base_pc   (base_pc)
);

// File: tb/tb_dual_buf_fetch.sv
`timescale 1ns/1ps
module tb_dual_buf_fetch;
  localparam int PC_W    = 8;
  localparam int INSTR_W = 38;
  localparam int NV      = 35;

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               imem_rd_en;
  logic [PC_W-1:0]    imem_addr;
  logic [INSTR_W-1:0] imem_rdata = '0;
  logic               mt_start = 1'b0, mt_advance = 1'b0, mt_fail = 1'b0, pc_load = 1'b0;
  logic [PC_W-1:0]    pc_load_addr = '0;
  logic               cur_valid;
  logic [PC_W-1:0]    cur_pc;
  logic [INSTR_W-1:0] cur_instr;
  logic               dec_open, dec_nop;
  logic [1:0]         dec_int_op;
  logic [2:0]         dec_ext_op;
  logic [31:0]        dec_ref;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dual_buf_fetch dut (.*);

  // instruction word stored at each address (R9 layout)
  function automatic logic [INSTR_W-1:0] word_at(input logic [7:0] a);
    logic [5:0] op;
    op = a[5:0] ^ 6'h2B;
    return {op, a, a ^ 8'h5A, a + 8'd3, ~a};
  endfunction

  // one-cycle-latency instruction memory (R2)
  always_ff @(posedge clk) if (imem_rd_en) imem_rdata <= word_at(imem_addr);

  // {load, load_addr, start, advance, fail, exp_valid, exp_pc, req}
  function automatic logic [24:0] mk(input logic ld, input logic [7:0] la, input logic st,
      input logic ad, input logic fl, input logic ev, input logic [7:0] ep, input logic [3:0] rq);
    return {ld, la, st, ad, fl, ev, ep, rq};
  endfunction

  localparam logic [24:0] VEC [NV] = '{
    mk(0,  0,0,0,0, 0,  0, 1),  // R1 fill cycle
    mk(0,  0,0,0,0, 1,  0, 1),  // R1 first instruction
    mk(0,  0,0,0,0, 1,  0, 3),  // R3
    mk(0,  0,0,0,0, 1,  0, 3),
    mk(0,  0,1,0,0, 1,  1, 4),  // R4 start
    mk(0,  0,0,1,0, 1,  2, 4),  // advance uses in-flight fill
    mk(0,  0,0,1,0, 1,  3, 4),
    mk(0,  0,0,0,1, 1,  0, 5),  // R5 fail
    mk(0,  0,1,0,0, 1,  1, 5),  // start right after fail
    mk(0,  0,0,0,1, 1,  0, 5),
    mk(0,  0,0,0,0, 1,  0, 3),
    mk(0,  0,0,1,0, 1,  0, 6),  // R6 advance in search
    mk(0,  0,0,0,1, 1,  0, 6),  // fail in search
    mk(0,  0,1,0,0, 1,  1, 4),
    mk(0,  0,1,0,0, 1,  1, 6),  // start in match
    mk(0,  0,0,1,0, 1,  2, 4),
    mk(1, 40,0,1,0, 0,  0, 7),  // R7 load beats advance
    mk(0,  0,0,0,0, 1, 40, 7),
    mk(0,  0,1,0,0, 1, 41, 4),
    mk(0,  0,0,1,0, 1, 42, 4),
    mk(0,  0,0,1,1, 1, 40, 8),  // R8 fail beats advance
    mk(1,254,0,0,0, 0,  0, 7),
    mk(0,  0,0,0,0, 1,254, 7),
    mk(0,  0,1,0,0, 1,255, 4),
    mk(0,  0,0,1,0, 1,  0,10),  // R10 wrap
    mk(0,  0,0,0,1, 1,254, 5),
    mk(1,  7,0,0,0, 0,  0, 7),
    mk(1,  9,0,0,0, 0,  0, 7),  // back-to-back loads
    mk(0,  0,0,0,0, 1,  9, 7),
    mk(1, 20,0,0,0, 0,  0, 7),
    mk(0,  0,1,0,0, 1, 20, 6),  // start while empty ignored
    mk(0,  0,0,1,0, 1, 20, 6),
    mk(0,  0,1,0,0, 1, 21, 4),
    mk(1, 60,0,0,1, 0,  0, 7),  // load beats fail
    mk(0,  0,0,0,0, 1, 60, 7)
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_cur(input string req, input logic [7:0] epc);
    logic [INSTR_W-1:0] w;
    w = word_at(epc);
    chk(req, 64'(cur_valid), 64'd1);
    chk(req, 64'(cur_pc), 64'(epc));
    chk(req, 64'(cur_instr), 64'(w));
    chk("R9 open", 64'(dec_open), 64'(w[37]));
    chk("R9 int", 64'(dec_int_op), 64'(w[36:35]));
    chk("R9 ext", 64'(dec_ext_op), 64'(w[34:32]));
    chk("R9 ref", 64'(dec_ref), 64'(w[31:0]));
    chk("R9 nop", 64'(dec_nop), 64'(w[37:32] == 6'd0));
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 valid in reset", 64'(cur_valid), 64'd0);
    rst = 1'b0;
    #1;
    chk("R2 read enable", 64'(imem_rd_en), 64'd1);
    chk("R2 read address", 64'(imem_addr), 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      string tag;
      v = VEC[i];
      pc_load      = v[24];
      pc_load_addr = v[23:16];
      mt_start     = v[15];
      mt_advance   = v[14];
      mt_fail      = v[13];
      @(negedge clk);
      tag = $sformatf("R%0d step %0d", v[3:0], i);
      if (v[12]) chk_cur(tag, v[11:4]);
      else       chk(tag, 64'(cur_valid), 64'd0);
    end

    // R9: nop marker at address 43
    pc_load = 1'b1; pc_load_addr = 8'd43; mt_start = 1'b0; mt_advance = 1'b0; mt_fail = 1'b0;
    @(negedge clk);
    pc_load = 1'b0;
    @(negedge clk);
    chk_cur("R9 nop word", 8'd43);
    chk("R9 nop flag", 64'(dec_nop), 64'd1);

    // R1: reset in the middle of a match
    mt_start = 1'b1;
    @(negedge clk);
    mt_start = 1'b0;
    chk_cur("R4 before reset", 8'd44);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 valid after reset", 64'(cur_valid), 64'd0);
    rst = 1'b0;
    #1;
    chk("R2 address after reset", 64'(imem_addr), 64'd0);
    @(negedge clk);
    chk("R1 fill cycle", 64'(cur_valid), 64'd0);
    @(negedge clk);
    chk_cur("R1 restart at 0", 8'd0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule